// File: doc/BRIEF.md
# Critical-Word-First Line Refill Controller

This controller handles a read miss on one cache line of several words. When the processor reads a line that the controller does not hold, the controller issues a single memory command. The command names the line and the word the processor wants. Memory then returns every word of the line, one beat at a time. The first beat is the requested word, and the later beats step upward through the line, wrapping from the top index back to index zero. The controller does not wait for the whole line. It hands the requested word to the processor in the cycle after that word arrives, and it keeps storing the remaining beats in the background.

Each word of the held line has its own valid bit. While the fill runs, a read of a word that has already arrived is answered at once. A read of a word that has not yet arrived is held with a stall until its beat comes in. A read of a different line waits until the current fill ends, and then starts a new fill. When the last beat is stored, a one-cycle completion pulse is raised and the line reads as fully valid.

The tag array, the replacement choice and all write traffic belong to the surrounding cache and are not part of this block. The line length must be a power of two. The default is 8 words.

Top module: `cwf_refill_ctrl`

## Requirements
- R1: A read to a line that is not held, made while no fill is active, produces a `mem_req` pulse one cycle long. The pulse is high in the cycle after the clock edge that sampled the read. During that pulse, `mem_line` carries the read's line and `mem_word` carries the read's word index.
- R2: During a fill, the k-th `mem_rvalid` beat (counting from 0) is stored at word index (`mem_word` + k) mod 8. Every stored word later reads back as the data of its own beat.
- R3: The processor's requested word is returned on `cpu_rdata`, with `cpu_ack` high, in the cycle right after its beat arrives. At that point `line_full` is still low.
- R4: The fill keeps storing all 8 beats. `fill_done` is a one-cycle pulse in the cycle after the eighth beat, and `line_full` is high from that cycle on.
- R5: A read of the held line whose word is already valid gets `cpu_ack` with the stored data in the next cycle, both during a fill and after it.
- R6: A read of the held line whose word has not arrived raises `cpu_stall` combinationally. It is acknowledged in the cycle after that word's beat.
- R7: A read of a different line during a fill stalls and issues no memory command until the fill ends. Its `mem_req` appears in the cycle after `fill_done`.
- R8: `mem_rvalid` beats that arrive while no fill is active have no effect. Stored words, `line_full` and `fill_done` are all left unchanged.
- R9: After reset no line is held, and `cpu_ack`, `cpu_stall`, `mem_req`, `fill_done` and `line_full` are all low. The first read after reset therefore always misses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor read request, held until acknowledged |
| cpu_line | input | LINE_W | Line address of the read |
| cpu_word | input | IDX_W | Word index within the line |
| cpu_stall | output | 1 | Read pending and not served this cycle |
| cpu_ack | output | 1 | Read data valid on cpu_rdata |
| cpu_rdata | output | DATA_W | Read data |
| mem_req | output | 1 | One-cycle refill command to memory |
| mem_line | output | LINE_W | Line being refilled |
| mem_word | output | IDX_W | Critical word index, fetched first |
| mem_rvalid | input | 1 | Memory beat valid |
| mem_rdata | input | DATA_W | Memory beat data |
| fill_done | output | 1 | Pulse after the last beat is stored |
| line_full | output | 1 | All words of the held line are valid |

## Verification
Every result has a fixed distance from the event that causes it. The memory command is due one cycle after a missing read is sampled. An acknowledge is due one cycle after a hit is sampled, or one cycle after the beat carrying the wanted word. The completion pulse is due one cycle after the eighth beat. The bench's memory model records the posedge count at which each beat and each command is seen, and every check compares the cycle of the observed output against that recorded cycle plus the expected distance. All sampling happens on the falling edge.

// File: rtl/cwf_pkg.sv
`timescale 1ns/1ps
package cwf_pkg;

    localparam int CWF_WORDS  = 8;
    localparam int CWF_DATA_W = 32;
    localparam int CWF_LINE_W = 24;

    typedef enum logic {
        FILL_IDLE = 1'b0,
        FILL_BUSY = 1'b1
    } fill_state_e;

    // Where a read is answered from in the current cycle.
    typedef struct packed {
        logic from_line;   // word already valid in the line store
        logic from_beat;   // word arriving on the memory beat right now
    } serve_src_t;

endpackage

// File: rtl/cwf_wrap_ctr.sv
`timescale 1ns/1ps
module cwf_wrap_ctr #(
    parameter int WORDS = 8,
    parameter int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [IDX_W-1:0] load_idx,
    input  logic             step,
    output logic [IDX_W-1:0] idx,
    output logic             last
);

    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] cnt_q;

    // Index wraps by natural overflow: WORDS is a power of two.
    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            idx_q <= load_idx;
            cnt_q <= '0;
        end else if (step) begin
            idx_q <= idx_q + 1'b1;
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign idx  = idx_q;
    assign last = (cnt_q == IDX_W'(WORDS - 1));

endmodule

// File: rtl/cwf_line_store.sv
`timescale 1ns/1ps
module cwf_line_store #(
    parameter int WORDS  = 8,
    parameter int DATA_W = 32,
    parameter int IDX_W  = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic [WORDS-1:0]  vld
);

    logic [DATA_W-1:0] word_data [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        logic              v_q;
        logic [DATA_W-1:0] d_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                v_q <= 1'b0;
                d_q <= '0;
            end else if (clear) begin
                v_q <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                v_q <= 1'b1;
                d_q <= wr_data;
            end
        end

        assign word_data[g] = d_q;
        assign vld[g]       = v_q;
    end

    assign rd_data = word_data[rd_idx];

endmodule

// File: rtl/cwf_refill_ctrl.sv
`timescale 1ns/1ps
module cwf_refill_ctrl
    import cwf_pkg::*;
#(
    parameter int WORDS  = CWF_WORDS,
    parameter int DATA_W = CWF_DATA_W,
    parameter int LINE_W = CWF_LINE_W,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic [LINE_W-1:0] cpu_line,
    input  logic [IDX_W-1:0]  cpu_word,
    output logic              cpu_stall,
    output logic              cpu_ack,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic [LINE_W-1:0] mem_line,
    output logic [IDX_W-1:0]  mem_word,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              fill_done,
    output logic              line_full
);

    fill_state_e       st_q;
    logic              busy;
    logic              have_q;
    logic [LINE_W-1:0] line_q;
    logic              line_hit;
    logic              beat;
    logic              start;
    logic              serve;
    serve_src_t        src;
    logic [IDX_W-1:0]  beat_idx;
    logic              beat_last;
    logic [WORDS-1:0]  word_vld;
    logic [DATA_W-1:0] held_word;

    assign busy     = (st_q == FILL_BUSY);
    assign line_hit = have_q && (cpu_line == line_q);
    assign beat     = busy && mem_rvalid;      // beats outside a fill are dropped

    always_comb begin
        src.from_line = cpu_req && line_hit && word_vld[cpu_word];
        src.from_beat = cpu_req && line_hit && beat && (beat_idx == cpu_word);
    end

    assign serve = src.from_line | src.from_beat;
    assign start = cpu_req && !line_hit && !busy;

    cwf_wrap_ctr #(
        .WORDS (WORDS),
        .IDX_W (IDX_W)
    ) i_ctr (
        .clk      (clk),
        .rst      (rst),
        .load     (start),
        .load_idx (cpu_word),
        .step     (beat),
        .idx      (beat_idx),
        .last     (beat_last)
    );

    cwf_line_store #(
        .WORDS  (WORDS),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) i_store (
        .clk     (clk),
        .rst     (rst),
        .clear   (start),
        .wr_en   (beat),
        .wr_idx  (beat_idx),
        .wr_data (mem_rdata),
        .rd_idx  (cpu_word),
        .rd_data (held_word),
        .vld     (word_vld)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= FILL_IDLE;
            have_q    <= 1'b0;
            line_q    <= '0;
            mem_word  <= '0;
            mem_req   <= 1'b0;
            cpu_ack   <= 1'b0;
            cpu_rdata <= '0;
            fill_done <= 1'b0;
        end else begin
            cpu_ack   <= serve;
            mem_req   <= start;
            fill_done <= beat && beat_last;
            if (serve) begin
                cpu_rdata <= src.from_line ? held_word : mem_rdata;
            end
            if (start) begin
                st_q     <= FILL_BUSY;
                have_q   <= 1'b1;
                line_q   <= cpu_line;
                mem_word <= cpu_word;
            end else if (beat && beat_last) begin
                st_q <= FILL_IDLE;
            end
        end
    end

    assign mem_line  = line_q;
    assign cpu_stall = cpu_req && !serve;
    assign line_full = &word_vld;

endmodule

// File: rtl/cwf_refill_chk.sv
`timescale 1ns/1ps
module cwf_refill_chk #(
    parameter int WORDS = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             cpu_req,
    input logic             cpu_ack,
    input logic             mem_req,
    input logic             mem_rvalid,
    input logic             fill_done,
    input logic             line_full,
    input logic             busy,
    input logic [WORDS-1:0] valid_vec
);

    // R1: the memory command lasts one cycle
    a_r1_req_pulse: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    // R1: a new fill starts from an empty line
    a_r1_req_clears: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !line_full);

    // R3: an acknowledge answers a pending read
    a_r3_ack_has_req: assert property (@(posedge clk) disable iff (rst)
        cpu_ack |-> $past(cpu_req));

    // R2: at most one word becomes valid per beat
    a_r2_one_word_per_cycle: assert property (@(posedge clk) disable iff (rst)
        !mem_req |-> ($countones(valid_vec) <= $countones($past(valid_vec)) + 1));

    // R4: completion implies a full line, and is a single pulse
    a_r4_done_full: assert property (@(posedge clk) disable iff (rst)
        fill_done |-> line_full);
    a_r4_done_pulse: assert property (@(posedge clk) disable iff (rst)
        fill_done |=> !fill_done);

    // R7: no new command while a fill was running
    a_r7_no_req_in_fill: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !$past(busy));

    // R8: idle beats leave the line untouched
    a_r8_idle_beat_ignored: assert property (@(posedge clk) disable iff (rst)
        (!busy && mem_rvalid && !cpu_req) |=> $stable(valid_vec));

endmodule

bind cwf_refill_ctrl cwf_refill_chk #(
    .WORDS (WORDS)
) i_chk (
    .clk        (clk),
    .rst        (rst),
    .cpu_req    (cpu_req),
    .cpu_ack    (cpu_ack),
    .mem_req    (mem_req),
    .mem_rvalid (mem_rvalid),
    .fill_done  (fill_done),
    .line_full  (line_full),
    .busy       (busy),
    .valid_vec  (word_vld)
);

// File: tb/test_cwf_refill_ctrl.sv
`timescale 1ns/1ps
module test_cwf_refill_ctrl;

    localparam int WORDS = 8;
    localparam int DW    = 32;
    localparam int LW    = 24;

    typedef struct packed {
        logic [LW-1:0] line;
        logic [2:0]    word;
        logic [3:0]    lat;
        logic [3:0]    gap;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{24'h000000, 3'd3, 4'd0, 4'd0},
        '{24'h0000A1, 3'd0, 4'd1, 4'd0},
        '{24'h0BEEF2, 3'd7, 4'd3, 4'd1},
        '{24'h123453, 3'd6, 4'd0, 4'd2},
        '{24'h00FF04, 3'd1, 4'd2, 4'd0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cpu_req;
    logic [LW-1:0] cpu_line;
    logic [2:0]    cpu_word;
    logic          cpu_stall, cpu_ack, mem_req, fill_done, line_full;
    logic [DW-1:0] cpu_rdata;
    logic [LW-1:0] mem_line;
    logic [2:0]    mem_word;
    logic          mem_rvalid;
    logic [DW-1:0] mem_rdata;

    always #10 clk = ~clk;   // 50 MHz

    cwf_refill_ctrl i_cwf_refill_ctrl (
        .clk (clk), .rst (rst),
        .cpu_req (cpu_req), .cpu_line (cpu_line), .cpu_word (cpu_word),
        .cpu_stall (cpu_stall), .cpu_ack (cpu_ack), .cpu_rdata (cpu_rdata),
        .mem_req (mem_req), .mem_line (mem_line), .mem_word (mem_word),
        .mem_rvalid (mem_rvalid), .mem_rdata (mem_rdata),
        .fill_done (fill_done), .line_full (line_full)
    );

    int n_chk = 0;
    int n_bad = 0;
    int pcyc  = 0;

    always @(posedge clk) pcyc <= pcyc + 1;

    function automatic logic [DW-1:0] mdata(input logic [LW-1:0] ln, input logic [2:0] ix);
        return {ln ^ 24'h5A3C96, 5'd0, ix};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    int            m_beat = -1;
    int            m_wait = 0;
    int            m_lat  = 0;
    int            m_gap  = 0;
    logic [LW-1:0] m_line;
    logic [2:0]    m_crit;
    int            beat_cyc [WORDS];
    int            req_cyc = -1;
    logic [LW-1:0] req_line;
    logic [2:0]    req_word;
    bit            junk = 1'b0;

    always @(negedge clk) begin : mem_model
        logic [2:0] ix;
        mem_rvalid = 1'b0;
        mem_rdata  = '0;
        if (rst) begin
            m_beat = -1;
        end else if (mem_req) begin
            req_cyc  = pcyc;
            req_line = mem_line;
            req_word = mem_word;
            m_line   = mem_line;
            m_crit   = mem_word;
            m_beat   = 0;
            m_wait   = m_lat;
            for (int i = 0; i < WORDS; i++) beat_cyc[i] = -1;
        end else if (m_beat >= 0) begin
            if (m_wait > 0) begin
                m_wait--;
            end else begin
                ix          = m_crit + 3'(m_beat);
                mem_rvalid  = 1'b1;
                mem_rdata   = mdata(m_line, ix);
                beat_cyc[ix] = pcyc;
                m_beat++;
                if (m_beat == WORDS) m_beat = -1;
                m_wait = m_gap;
            end
        end else if (junk) begin
            mem_rvalid = 1'b1;
            mem_rdata  = 32'hDEAD_BEEF;
        end
    end

    int done_cnt = 0;
    int done_cyc = -1;
    always @(negedge clk) begin
        if (!rst && fill_done) begin
            done_cnt++;
            done_cyc = pcyc;
        end
    end

    // ---------------- processor read ----------------
    task automatic rd(input logic [LW-1:0] ln, input logic [2:0] w,
                      output int waited, output logic [DW-1:0] data,
                      output bit stall0, output int t0, output int tack);
        cpu_line = ln;
        cpu_word = w;
        cpu_req  = 1'b1;
        t0       = pcyc;
        #1 stall0 = cpu_stall;
        waited = 0;
        do begin
            @(negedge clk);
            waited++;
        end while (!cpu_ack && waited < 400);
        tack = pcyc;
        data = cpu_rdata;
        cpu_req = 1'b0;
        if (!cpu_ack) chk(1'b0, "R6 read never acknowledged", 32'(waited), 32'd400);
    endtask

    task automatic wait_done(input int prev);
        int k = 0;
        while (done_cnt == prev && k < 400) begin
            @(negedge clk);
            k++;
        end
        chk(done_cnt != prev, "R4 fill_done seen", 32'(done_cnt), 32'(prev + 1));
    endtask

    initial begin : watchdog
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int            waited, t0, tack, pd;
        bit            st0;
        logic [DW-1:0] data;
        logic [LW-1:0] la, lb;

        cpu_req  = 1'b0;
        cpu_line = '0;
        cpu_word = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk(line_full == 1'b0, "R9 line_full after reset", 32'(line_full), 32'd0);
        chk(cpu_ack   == 1'b0, "R9 cpu_ack after reset",   32'(cpu_ack),   32'd0);
        chk(mem_req   == 1'b0, "R9 mem_req after reset",   32'(mem_req),   32'd0);
        chk(fill_done == 1'b0, "R9 fill_done after reset", 32'(fill_done), 32'd0);
        chk(cpu_stall == 1'b0, "R9 cpu_stall after reset", 32'(cpu_stall), 32'd0);

        // ---------------- vector table: full miss, fill, read-back ----------------
        for (int v = 0; v < 5; v++) begin
            m_lat = int'(VECS[v].lat);
            m_gap = int'(VECS[v].gap);
            pd    = done_cnt;
            rd(VECS[v].line, VECS[v].word, waited, data, st0, t0, tack);
            chk(req_cyc == t0 + 1, "R1 mem_req cycle", 32'(req_cyc), 32'(t0 + 1));
            chk(req_line == VECS[v].line, "R1 mem_line", 32'(req_line), 32'(VECS[v].line));
            chk(req_word == VECS[v].word, "R1 mem_word", 32'(req_word), 32'(VECS[v].word));
            chk(st0 == 1'b1, "R6 miss stalls (R9 on first)", 32'(st0), 32'd1);
            chk(data == mdata(VECS[v].line, VECS[v].word), "R3 critical data", data,
                mdata(VECS[v].line, VECS[v].word));
            chk(tack == beat_cyc[VECS[v].word] + 1, "R3 forward cycle", 32'(tack),
                32'(beat_cyc[VECS[v].word] + 1));
            chk(line_full == 1'b0, "R3 line not full at forward", 32'(line_full), 32'd0);
            wait_done(pd);
            chk(done_cyc == beat_cyc[VECS[v].word - 3'd1] + 1, "R4 done cycle", 32'(done_cyc),
                32'(beat_cyc[VECS[v].word - 3'd1] + 1));
            chk(line_full == 1'b1, "R4 line_full at done", 32'(line_full), 32'd1);
            @(negedge clk);
            chk(fill_done == 1'b0, "R4 done is a pulse", 32'(fill_done), 32'd0);
            chk(line_full == 1'b1, "R4 line_full holds", 32'(line_full), 32'd1);
            for (int i = 0; i < WORDS; i++) begin
                rd(VECS[v].line, 3'(i), waited, data, st0, t0, tack);
                chk(waited == 1, "R5 hit latency", 32'(waited), 32'd1);
                chk(data == mdata(VECS[v].line, 3'(i)), "R2 stored word", data,
                    mdata(VECS[v].line, 3'(i)));
            end
        end

        // ---------------- hits and stalls during a slow fill ----------------
        la    = 24'h5A5A05;
        m_lat = 2;
        m_gap = 3;
        pd    = done_cnt;
        rd(la, 3'd5, waited, data, st0, t0, tack);
        chk(tack == beat_cyc[5] + 1, "R3 slow forward cycle", 32'(tack), 32'(beat_cyc[5] + 1));
        chk(data == mdata(la, 3'd5), "R3 slow forward data", data, mdata(la, 3'd5));
        rd(la, 3'd6, waited, data, st0, t0, tack);
        chk(st0 == 1'b1, "R6 stall on missing word", 32'(st0), 32'd1);
        chk(tack == beat_cyc[6] + 1, "R6 ack after its beat", 32'(tack), 32'(beat_cyc[6] + 1));
        chk(data == mdata(la, 3'd6), "R6 data", data, mdata(la, 3'd6));
        rd(la, 3'd5, waited, data, st0, t0, tack);
        chk(waited == 1, "R5 hit during fill", 32'(waited), 32'd1);
        chk(line_full == 1'b0, "R5 fill still running", 32'(line_full), 32'd0);
        chk(data == mdata(la, 3'd5), "R5 data during fill", data, mdata(la, 3'd5));
        rd(la, 3'd4, waited, data, st0, t0, tack);
        chk(st0 == 1'b1, "R6 stall on last word", 32'(st0), 32'd1);
        chk(tack == beat_cyc[4] + 1, "R6 last word cycle", 32'(tack), 32'(beat_cyc[4] + 1));
        chk(data == mdata(la, 3'd4), "R6 last word data", data, mdata(la, 3'd4));
        @(negedge clk);
        chk(done_cnt == pd + 1, "R4 one done per fill", 32'(done_cnt), 32'(pd + 1));
        chk(done_cyc == tack, "R4 done with last beat", 32'(done_cyc), 32'(tack));

        // ---------------- other line during a fill ----------------
        la    = 24'h0C0C06;
        lb    = 24'h0D0D07;
        m_lat = 0;
        m_gap = 2;
        pd    = done_cnt;
        rd(la, 3'd2, waited, data, st0, t0, tack);
        chk(data == mdata(la, 3'd2), "R3 first line data", data, mdata(la, 3'd2));
        rd(lb, 3'd0, waited, data, st0, t0, tack);
        chk(st0 == 1'b1, "R7 other line stalls", 32'(st0), 32'd1);
        chk(req_line == lb, "R7 new command line", 32'(req_line), 32'(lb));
        chk(req_cyc == done_cyc + 1, "R7 command after done", 32'(req_cyc), 32'(done_cyc + 1));
        chk(data == mdata(lb, 3'd0), "R7 second line data", data, mdata(lb, 3'd0));
        wait_done(pd + 1);

        // ---------------- stray beats while idle ----------------
        @(negedge clk);
        pd   = done_cnt;
        junk = 1'b1;
        repeat (5) @(negedge clk);
        junk = 1'b0;
        @(negedge clk);
        chk(done_cnt == pd, "R8 no done from stray beats", 32'(done_cnt), 32'(pd));
        chk(line_full == 1'b1, "R8 line_full kept", 32'(line_full), 32'd1);
        for (int i = 0; i < WORDS; i++) begin
            rd(lb, 3'(i), waited, data, st0, t0, tack);
            chk(data == mdata(lb, 3'(i)), "R8 word unchanged", data, mdata(lb, 3'(i)));
            chk(waited == 1, "R8 still a hit", 32'(waited), 32'd1);
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule